// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block is the host-facing command interpreter of a byte-wide parallel NOR-flash model. It watches write cycles formed from an active-low chip enable, an active-low write enable, an address bus and an 8-bit data bus, all sampled on a system clock. It recognises the key-prefixed command sequences for byte program, whole-device erase, sector erase, identification and reset. It then chooses what a read returns: array data, identification codes or operation status.

Accepted operations go to an embedded operation engine as requests on a valid/ready channel. A request stays asserted with its kind, address and data held unchanged until the engine accepts it with ready high on a clock edge. While a request is waiting, and while the engine reports that it is busy or has timed out, the sequence tracker is frozen. Writes in that window are filtered as the requirements describe. The engine reports its state back through plain busy and timeout inputs.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A write cycle is the interval in which both enables are low. The address is captured in the first clock of that interval, which is the later of the two falling edges. The data is captured in the last clock, just before the earlier rising edge. Values on the buses at other times have no effect, whichever enable falls first.
- R2: Key writes 0xAA at 0x555 and 0x55 at 0x2AA (low 11 address bits compared), then 0xA0 at 0x555, then one more write. This issues a request with kind 1 (program) that carries the address and data of that last write.
- R3: Key, key, 0x80 at 0x555, key, key, then 0x10 at 0x555 issues a request of kind 2 (whole-device erase).
- R4: The same five-write prefix followed by 0x30 at any address issues a request of kind 3 (sector erase) that carries that address.
- R5: Key, key, 0x90 at 0x555 sets read mode 1 (identification). In that mode, offset 0 within a sector reads 0x1C and offset 1 reads 0x4F. Offset 2 reads that sector's protection flag in bit 0. The sector index is the top 3 address bits, and every other offset reads 0x00. The mode persists across any number of reads and across other writes.
- R6: 0xF0 written at any address, outside the program-data cycle, abandons any partial sequence and returns read mode to 0 (array).
- R7: A write that does not match the next expected cycle abandons the partial sequence. The decoder then needs a complete new sequence, starting from the first key write.
- R8: A request holds op_valid, op_kind, op_addr and op_data stable until op_ready is seen high. All writes made while it waits are ignored.
- R9: While the engine is busy with a whole-device erase, every write is ignored.
- R10: While the engine is busy with a sector erase, only 0xB0 (at any address) is accepted, and it issues a request of kind 4 (suspend). All other writes are ignored.
- R11: While eng_timeout is high, only 0xF0 is accepted, and it issues a request of kind 5 (abort) and clears identification mode.
- R12: rd_mode is 2 (status) whenever a request is pending, the engine is busy or a timeout is flagged; it never takes the value 3.
- R13: After reset, rd_mode is 0 and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_ce_n | input | 1 | Host chip enable, active low |
| bus_we_n | input | 1 | Host write enable, active low |
| bus_addr | input | ADDR_W | Host address bus |
| bus_dq | input | 8 | Host write data |
| rd_addr | input | ADDR_W | Address of the current identification read |
| sect_prot | input | NSECT | Per-sector protection flags |
| id_data | output | 8 | Identification read data |
| rd_mode | output | 2 | 0 array, 1 identification, 2 status |
| op_valid | output | 1 | Engine request valid |
| op_ready | input | 1 | Engine accepts the request |
| op_kind | output | 3 | 1 program, 2 device erase, 3 sector erase, 4 suspend, 5 abort |
| op_addr | output | ADDR_W | Request address |
| op_data | output | 8 | Request data |
| eng_busy | input | 1 | Engine is running an operation |
| eng_timeout | input | 1 | Engine reports an exceeded time limit |

## Verification
The assertions check the request channel on every cycle. They cover a request held stable under back-pressure, status mode whenever anything is in flight, the absence of the unused mode code, and the rule that no request other than suspend appears while the engine is busy and that abort appears only after a timeout. Whether a given series of writes forms a legal sequence can only be shown by the bench's scenarios. The same holds for the address and data of each cycle being taken at the right enable edges, a mismatch forcing a fresh start, and identification mode lasting until reset.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int KEY_W = 11;

  localparam logic [KEY_W-1:0] KEY_ADDR_A = 11'h555;
  localparam logic [KEY_W-1:0] KEY_ADDR_B = 11'h2AA;

  localparam logic [7:0] CMD_KEY_A   = 8'hAA;
  localparam logic [7:0] CMD_KEY_B   = 8'h55;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_PROG    = 8'hA0;
  localparam logic [7:0] CMD_ESETUP  = 8'h80;
  localparam logic [7:0] CMD_CHIP    = 8'h10;
  localparam logic [7:0] CMD_SECT    = 8'h30;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_RESET   = 8'hF0;

  localparam logic [2:0] OP_NONE  = 3'd0;
  localparam logic [2:0] OP_PROG  = 3'd1;
  localparam logic [2:0] OP_CHIP  = 3'd2;
  localparam logic [2:0] OP_SECT  = 3'd3;
  localparam logic [2:0] OP_SUSP  = 3'd4;
  localparam logic [2:0] OP_ABORT = 3'd5;

  localparam logic [1:0] RD_ARRAY  = 2'd0;
  localparam logic [1:0] RD_IDENT  = 2'd1;
  localparam logic [1:0] RD_STATUS = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_K1, S_K2, S_PDATA, S_E0, S_E1, S_E2
  } seq_state_e;
endpackage

// File: rtl/flash_bus_sampler.sv
module flash_bus_sampler
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              key_a_hit,
  output logic              key_b_hit
);
  logic act;
  logic act_q;

  assign act = !ce_n && !we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      act_q  <= act;
      wr_stb <= act_q && !act;
      if (act && !act_q) wr_addr <= addr;
      if (act) wr_data <= dq;
    end
  end

  assign key_a_hit = (wr_addr[KEY_W-1:0] == KEY_ADDR_A);
  assign key_b_hit = (wr_addr[KEY_W-1:0] == KEY_ADDR_B);
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stb,
  input  logic       key_a,
  input  logic       key_b,
  input  logic [7:0] data,
  input  logic       clear_all,
  output logic       launch,
  output logic [2:0] launch_kind,
  output logic       ident_on
);
  seq_state_e st, nxt;
  logic       ident_nxt;

  always_comb begin
    nxt         = st;
    launch      = 1'b0;
    launch_kind = OP_NONE;
    ident_nxt   = ident_on;
    if (stb) begin
      nxt = S_IDLE;
      if (data == CMD_RESET && st != S_PDATA) begin
        ident_nxt = 1'b0;
      end else begin
        case (st)
          S_IDLE: if (key_a && data == CMD_KEY_A) nxt = S_K1;
          S_K1:   if (key_b && data == CMD_KEY_B) nxt = S_K2;
          S_K2: begin
            if (key_a) begin
              case (data)
                CMD_IDENT:  ident_nxt = 1'b1;
                CMD_PROG:   nxt = S_PDATA;
                CMD_ESETUP: nxt = S_E0;
                default:    nxt = S_IDLE;
              endcase
            end
          end
          S_PDATA: begin
            launch      = 1'b1;
            launch_kind = OP_PROG;
          end
          S_E0: if (key_a && data == CMD_KEY_A) nxt = S_E1;
          S_E1: if (key_b && data == CMD_KEY_B) nxt = S_E2;
          S_E2: begin
            if (key_a && data == CMD_CHIP) begin
              launch      = 1'b1;
              launch_kind = OP_CHIP;
            end else if (data == CMD_SECT) begin
              launch      = 1'b1;
              launch_kind = OP_SECT;
            end
          end
          default: nxt = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ident_on <= 1'b0;
    end else if (clear_all) begin
      st       <= S_IDLE;
      ident_on <= 1'b0;
    end else begin
      st       <= nxt;
      ident_on <= ident_nxt;
    end
  end
endmodule

// File: rtl/flash_op_port.sv
module flash_op_port
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              seq_launch,
  input  logic [2:0]        seq_kind,
  input  logic              eng_busy,
  input  logic              eng_timeout,
  input  logic              op_ready,
  output logic              op_valid,
  output logic [2:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data,
  output logic              abort_fire
);
  logic [2:0] run_kind;
  logic       susp_fire;

  assign abort_fire = !op_valid && wr_stb && eng_timeout && wr_data == CMD_RESET;
  assign susp_fire  = !op_valid && wr_stb && !eng_timeout && eng_busy &&
                      run_kind == OP_SECT && wr_data == CMD_SUSPEND;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_valid <= 1'b0;
      op_kind  <= OP_NONE;
      op_addr  <= '0;
      op_data  <= '0;
      run_kind <= OP_NONE;
    end else if (op_valid) begin
      if (op_ready) op_valid <= 1'b0;
    end else if (seq_launch) begin
      op_valid <= 1'b1;
      op_kind  <= seq_kind;
      op_addr  <= wr_addr;
      op_data  <= wr_data;
      run_kind <= seq_kind;
    end else if (abort_fire || susp_fire) begin
      op_valid <= 1'b1;
      op_kind  <= abort_fire ? OP_ABORT : OP_SUSP;
      op_addr  <= wr_addr;
      op_data  <= wr_data;
    end
  end
endmodule

// File: rtl/flash_ident_rom.sv
module flash_ident_rom #(
  parameter int          ADDR_W = 19,
  parameter int          NSECT  = 8,
  parameter logic [7:0]  MFR_ID = 8'h1C,
  parameter logic [7:0]  DEV_ID = 8'h4F
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NSECT-1:0]  sect_prot,
  output logic [7:0]        id_data
);
  localparam int SECT_W = $clog2(NSECT);
  localparam int OFF_W  = ADDR_W - SECT_W;

  logic [SECT_W-1:0] sect;
  logic [OFF_W-1:0]  off;

  assign sect = rd_addr[ADDR_W-1 -: SECT_W];
  assign off  = rd_addr[OFF_W-1:0];

  always_comb begin
    if (off == OFF_W'(0))      id_data = MFR_ID;
    else if (off == OFF_W'(1)) id_data = DEV_ID;
    else if (off == OFF_W'(2)) id_data = {7'd0, sect_prot[sect]};
    else                       id_data = 8'h00;
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W = 19,
  parameter int         NSECT  = 8,
  parameter logic [7:0] MFR_ID = 8'h1C,
  parameter logic [7:0] DEV_ID = 8'h4F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce_n,
  input  logic              bus_we_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_dq,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NSECT-1:0]  sect_prot,
  output logic [7:0]        id_data,
  output logic [1:0]        rd_mode,
  output logic              op_valid,
  input  logic              op_ready,
  output logic [2:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data,
  input  logic              eng_busy,
  input  logic              eng_timeout
);
  logic              wr_stb;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic              key_a_hit, key_b_hit;
  logic              seq_open;
  logic              seq_launch;
  logic [2:0]        seq_kind;
  logic              ident_on;
  logic              abort_fire;

  flash_bus_sampler #(.ADDR_W(ADDR_W)) u_smp (
    .clk(clk), .rst_n(rst_n), .ce_n(bus_ce_n), .we_n(bus_we_n),
    .addr(bus_addr), .dq(bus_dq), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .key_a_hit(key_a_hit), .key_b_hit(key_b_hit)
  );

  assign seq_open = !op_valid && !eng_busy && !eng_timeout;

  flash_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .stb(wr_stb && seq_open),
    .key_a(key_a_hit), .key_b(key_b_hit), .data(wr_data),
    .clear_all(abort_fire), .launch(seq_launch),
    .launch_kind(seq_kind), .ident_on(ident_on)
  );

  flash_op_port #(.ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .seq_launch(seq_launch), .seq_kind(seq_kind),
    .eng_busy(eng_busy), .eng_timeout(eng_timeout), .op_ready(op_ready),
    .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr),
    .op_data(op_data), .abort_fire(abort_fire)
  );

  flash_ident_rom #(
    .ADDR_W(ADDR_W), .NSECT(NSECT), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
  ) u_id (
    .rd_addr(rd_addr), .sect_prot(sect_prot), .id_data(id_data)
  );

  always_comb begin
    if (op_valid || eng_busy || eng_timeout) rd_mode = RD_STATUS;
    else if (ident_on)                       rd_mode = RD_IDENT;
    else                                     rd_mode = RD_ARRAY;
  end
endmodule

// File: rtl/flash_cmd_decoder_checker.sv
module flash_cmd_decoder_checker #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        rd_mode,
  input logic              op_valid,
  input logic              op_ready,
  input logic [2:0]        op_kind,
  input logic [ADDR_W-1:0] op_addr,
  input logic [7:0]        op_data,
  input logic              eng_busy,
  input logic              eng_timeout
);
  assert_req_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_ready |=> op_valid && $stable(op_kind) &&
                              $stable(op_addr) && $stable(op_data));

  assert_busy_status_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid || eng_busy || eng_timeout) |-> rd_mode == 2'd2);

  assert_mode_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mode != 2'd3);

  assert_busy_suspend_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_valid) && $past(eng_busy) && !$past(eng_timeout) |-> op_kind == 3'd4);

  assert_abort_timeout_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_valid) && op_kind == 3'd5 |-> $past(eng_timeout));

  assert_kind_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> op_kind != 3'd0 && op_kind <= 3'd5);
endmodule

bind flash_cmd_decoder flash_cmd_decoder_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_mode(rd_mode), .op_valid(op_valid),
  .op_ready(op_ready), .op_kind(op_kind), .op_addr(op_addr),
  .op_data(op_data), .eng_busy(eng_busy), .eng_timeout(eng_timeout)
);

// File: tb/flash_cmd_decoder_bench.sv
`timescale 1ns/1ps
module flash_cmd_decoder_bench;
  localparam int ADDR_W = 19;
  localparam int NSECT  = 8;
  localparam int NVEC   = 25;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ce_n = 1'b1, we_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        dq = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [NSECT-1:0]  sect_prot = 8'b0010_0100;
  logic [7:0]        id_data;
  logic [1:0]        rd_mode;
  logic              op_valid;
  logic              op_ready = 1'b0;
  logic [2:0]        op_kind;
  logic [ADDR_W-1:0] op_addr;
  logic [7:0]        op_data;
  logic              eng_busy = 1'b0, eng_timeout = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_we_n(we_n),
    .bus_addr(addr), .bus_dq(dq), .rd_addr(rd_addr), .sect_prot(sect_prot),
    .id_data(id_data), .rd_mode(rd_mode), .op_valid(op_valid),
    .op_ready(op_ready), .op_kind(op_kind), .op_addr(op_addr),
    .op_data(op_data), .eng_busy(eng_busy), .eng_timeout(eng_timeout)
  );

  // {addr[18:0], data[7:0], exp_valid, exp_kind[2:0], exp_mode[1:0], req[3:0]}
  localparam logic [36:0] VEC [NVEC] = '{
    {19'h00555, 8'hAA, 1'b0, 3'd0, 2'd0, 4'd2},  // R2 key
    {19'h002AA, 8'h55, 1'b0, 3'd0, 2'd0, 4'd2},
    {19'h00555, 8'hA0, 1'b0, 3'd0, 2'd0, 4'd2},
    {19'h12345, 8'h5A, 1'b1, 3'd1, 2'd2, 4'd2},  // R2 program request
    {19'h00555, 8'hAA, 1'b0, 3'd0, 2'd0, 4'd3},  // R3 device erase
    {19'h002AA, 8'h55, 1'b0, 3'd0, 2'd0, 4'd3},
    {19'h00555, 8'h80, 1'b0, 3'd0, 2'd0, 4'd3},
    {19'h00555, 8'hAA, 1'b0, 3'd0, 2'd0, 4'd3},
    {19'h002AA, 8'h55, 1'b0, 3'd0, 2'd0, 4'd3},
    {19'h00555, 8'h10, 1'b1, 3'd2, 2'd2, 4'd3},
    {19'h00555, 8'hAA, 1'b0, 3'd0, 2'd0, 4'd4},  // R4 sector erase
    {19'h002AA, 8'h55, 1'b0, 3'd0, 2'd0, 4'd4},
    {19'h00555, 8'h80, 1'b0, 3'd0, 2'd0, 4'd4},
    {19'h00555, 8'hAA, 1'b0, 3'd0, 2'd0, 4'd4},
    {19'h002AA, 8'h55, 1'b0, 3'd0, 2'd0, 4'd4},
    {19'h30000, 8'h30, 1'b1, 3'd3, 2'd2, 4'd4},
    {19'h00555, 8'hAA, 1'b0, 3'd0, 2'd0, 4'd5},  // R5 identification
    {19'h002AA, 8'h55, 1'b0, 3'd0, 2'd0, 4'd5},
    {19'h00555, 8'h90, 1'b0, 3'd0, 2'd1, 4'd5},
    {19'h00555, 8'hAA, 1'b0, 3'd0, 2'd1, 4'd7},  // R7 mismatch follows
    {19'h00123, 8'h77, 1'b0, 3'd0, 2'd1, 4'd7},
    {19'h002AA, 8'h55, 1'b0, 3'd0, 2'd1, 4'd7},
    {19'h00555, 8'hA0, 1'b0, 3'd0, 2'd1, 4'd7},
    {19'h01000, 8'h11, 1'b0, 3'd0, 2'd1, 4'd7},  // no program
    {19'h00000, 8'hF0, 1'b0, 3'd0, 2'd0, 4'd6}   // R6 single reset
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                        input bit we_first);
    @(negedge clk);
    if (we_first) we_n = 1'b0; else ce_n = 1'b0;
    addr = ~a; dq = ~d;
    @(negedge clk);
    if (we_first) ce_n = 1'b0; else we_n = 1'b0;
    addr = a; dq = 8'h3C;
    @(negedge clk);
    addr = a ^ 19'h155; dq = 8'hC3;
    @(negedge clk);
    dq = d;
    @(negedge clk);
    if (we_first) ce_n = 1'b1; else we_n = 1'b1;
    dq = ~d; addr = '1;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic accept();
    @(negedge clk) op_ready = 1'b1;
    @(negedge clk) op_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic erase_prefix();
    bus_wr(19'h555, 8'hAA, 0); bus_wr(19'h2AA, 8'h55, 0);
    bus_wr(19'h555, 8'h80, 0); bus_wr(19'h555, 8'hAA, 0);
    bus_wr(19'h2AA, 8'h55, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R13 watchdog actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    check(rd_mode == 2'd0 && !op_valid, "R13 reset state",
          {rd_mode, 1'b0, op_valid}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      logic [36:0] v;
      logic [31:0] got, exp;
      v = VEC[i];
      bus_wr(v[36:18], v[17:10], 0);
      got = {op_valid, op_kind, rd_mode};
      exp = {v[9], (v[9] ? v[8:6] : op_kind), v[5:4]};
      if (v[9]) begin
        check(got == exp && op_addr == v[36:18] && op_data == v[17:10],
              $sformatf("R%0d vector %0d", v[3:0], i),
              {got[5:0], op_data, 5'd0, op_addr[12:0]},
              {exp[5:0], v[17:10], 5'd0, v[30:18]});
        accept();
      end else begin
        check(got == exp, $sformatf("R%0d vector %0d", v[3:0], i), got, exp);
      end
    end

    // R1: write enable falls first, address/data only valid at the edges
    bus_wr(19'h555, 8'hAA, 1); bus_wr(19'h2AA, 8'h55, 1);
    bus_wr(19'h555, 8'hA0, 1); bus_wr(19'h0ABCD, 8'h96, 1);
    check(op_valid && op_kind == 3'd1 && op_addr == 19'h0ABCD && op_data == 8'h96,
          "R1 edge latching", {op_valid, op_kind, op_data, op_addr[15:0]},
          {1'b1, 3'd1, 8'h96, 16'hABCD});
    accept();

    // R5 identification reads
    bus_wr(19'h555, 8'hAA, 0); bus_wr(19'h2AA, 8'h55, 0); bus_wr(19'h555, 8'h90, 0);
    rd_addr = 19'h50000; #1;
    check(id_data == 8'h1C, "R5 manufacturer", id_data, 8'h1C);
    rd_addr = 19'h00001; #1;
    check(id_data == 8'h4F, "R5 device", id_data, 8'h4F);
    rd_addr = 19'h20002; #1;
    check(id_data == 8'h01, "R5 protected sector", id_data, 8'h01);
    rd_addr = 19'h30002; #1;
    check(id_data == 8'h00, "R5 open sector", id_data, 8'h00);
    rd_addr = 19'h20003; #1;
    check(id_data == 8'h00, "R5 other offset", id_data, 8'h00);
    bus_wr(19'h123, 8'h44, 0);
    check(rd_mode == 2'd1, "R5 mode persists", rd_mode, 2'd1);
    // R6 reset after the key writes
    bus_wr(19'h555, 8'hAA, 0); bus_wr(19'h2AA, 8'h55, 0); bus_wr(19'h7777, 8'hF0, 0);
    check(rd_mode == 2'd0, "R6 keyed reset", rd_mode, 2'd0);

    // R8 back-pressure
    bus_wr(19'h555, 8'hAA, 0); bus_wr(19'h2AA, 8'h55, 0);
    bus_wr(19'h555, 8'hA0, 0); bus_wr(19'h00042, 8'h24, 0);
    bus_wr(19'h555, 8'hAA, 0); bus_wr(19'h2AA, 8'h55, 0);
    bus_wr(19'h555, 8'hA0, 0); bus_wr(19'h00099, 8'h99, 0);
    check(op_valid && op_addr == 19'h42 && op_data == 8'h24 && rd_mode == 2'd2,
          "R8 held request", {op_valid, op_data, op_addr[7:0]}, {1'b1, 8'h24, 8'h42});
    accept();
    check(!op_valid, "R8 second sequence ignored", op_valid, 1'b0);

    // R9 device erase running
    erase_prefix(); bus_wr(19'h555, 8'h10, 0);
    check(op_valid && op_kind == 3'd2, "R9 device erase start", op_kind, 3'd2);
    accept();
    eng_busy = 1'b1;
    bus_wr(19'h0, 8'hB0, 0); bus_wr(19'h0, 8'hF0, 0);
    bus_wr(19'h555, 8'hAA, 0); bus_wr(19'h2AA, 8'h55, 0);
    bus_wr(19'h555, 8'hA0, 0); bus_wr(19'h11, 8'h11, 0);
    check(!op_valid && rd_mode == 2'd2, "R9 writes ignored", {op_valid, rd_mode}, 3'b010);
    eng_busy = 1'b0;
    bus_wr(19'h22, 8'h22, 0);
    check(!op_valid && rd_mode == 2'd0, "R9 no late program", {op_valid, rd_mode}, 3'b000);

    // R10 sector erase running
    erase_prefix(); bus_wr(19'h40000, 8'h30, 0);
    check(op_valid && op_kind == 3'd3 && op_addr == 19'h40000, "R10 sector erase start",
          op_kind, 3'd3);
    accept();
    eng_busy = 1'b1;
    bus_wr(19'h0, 8'hF0, 0);
    check(!op_valid, "R10 reset ignored", op_valid, 1'b0);
    bus_wr(19'h1234, 8'hB0, 0);
    check(op_valid && op_kind == 3'd4, "R10 suspend", {op_valid, op_kind}, {1'b1, 3'd4});
    accept();
    eng_busy = 1'b0;

    // R11 timeout
    bus_wr(19'h555, 8'hAA, 0); bus_wr(19'h2AA, 8'h55, 0); bus_wr(19'h555, 8'h90, 0);
    eng_timeout = 1'b1;
    @(negedge clk);
    check(rd_mode == 2'd2, "R11 status on timeout", rd_mode, 2'd2);
    bus_wr(19'h0, 8'hB0, 0);
    check(!op_valid, "R11 other write ignored", op_valid, 1'b0);
    bus_wr(19'h0, 8'hF0, 0);
    check(op_valid && op_kind == 3'd5, "R11 abort", {op_valid, op_kind}, {1'b1, 3'd5});
    accept();
    eng_timeout = 1'b0;
    @(negedge clk);
    check(rd_mode == 2'd0, "R11 back to array", rd_mode, 2'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule